// File: doc/BRIEF.md
# Two-Beat Burst Memory with Split Data Buses

This block is a synthesizable storage core that behaves like a double-data-rate memory with a separate write-data bus and read-data bus. Every accepted command moves exactly two words: the address given with the command, then its pair partner. The two clock edges of a true double-rate device are replaced here by one fast clock. Each tick of that clock stands for one half of the slow cycle. An internal phase bit, visible on `beat_ph`, marks which ticks are main-edge ticks and which are complementary-edge ticks.

A host issues a command on a main-edge tick by pulling the active-low strobe low. A write supplies its first data word one slow cycle later and its second word on the tick after that. Each word has its own pair of byte enables. A read returns its two words three and four ticks after the command, with `dout_vld` raised during both. A command may be issued on every slow cycle, and reads and writes may be mixed in any order.

Top module: `bsio_core`

## Requirements
- R1: While reset is active and right after it ends, `dout_vld` is 0, `dout` is all zeros and `beat_ph` is 0.
- R2: On a main-edge tick with `ld_n` high, nothing is scheduled. No memory word changes and no read beat appears, whatever `rw`, `addr`, `din` or `bw_n` carry.
- R3: On a main-edge tick with `ld_n` low, `rw` = 0 starts a write and `rw` = 1 starts a read.
- R4: A burst touches address A first and then A with bit 0 inverted. An odd A is therefore followed by A-1, so the pair wraps inside its aligned pair.
- R5: For a write whose command is on tick t, the first word is taken from `din`/`bw_n` on tick t+2 (a main edge). The second word is taken on tick t+3 (a complementary edge).
- R6: For a read whose command is on tick t, the first word is on `dout` with `dout_vld` = 1 after tick t+3, and the second word after tick t+4. On every other tick `dout_vld` is 0 and `dout` is zero.
- R7: `bw_n[0]` low writes bits 8:0 and `bw_n[1]` low writes bits 17:9. A lane whose select is high keeps its old contents, and with both high nothing changes.
- R8: The byte selects are taken separately for each of the two write beats, so the two words of one burst may use different masks.
- R9: A read issued one slow cycle after a write to the same pair returns the newly written words.
- R10: Commands accepted on consecutive slow cycles, in any mix of reads and writes, do not disturb each other's beats. Back-to-back reads give four contiguous valid ticks.
- R11: `beat_ph` alternates on every tick after reset. A value of 0 means the next edge is a main edge.
- R12: `ld_n`, `rw` and `addr` are ignored on complementary-edge ticks (`beat_ph` = 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock, one edge per half slow cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_n | input | 1 | Active-low command strobe, looked at on main-edge ticks |
| rw | input | 1 | Operation select: 0 write, 1 read |
| addr | input | AW | First address of the burst |
| din | input | DW | Write data, taken on the two write-beat ticks |
| bw_n | input | NB | Active-low per-byte write selects, one per lane |
| dout | output | DW | Read data, zero when not valid |
| dout_vld | output | 1 | High on the ticks that carry a read beat |
| beat_ph | output | 1 | Phase of the next edge: 0 main, 1 complementary |

## Verification
The storage is first filled with distinct full-mask writes to every pair, then read back with idle cycles between commands. This separates the latency and order of the beats from any interaction between commands. Writes and reads at odd addresses expose a wrong pair-partner address. Per-beat mask combinations, including all-masked beats, separate lane mapping from beat mapping. Idle cycles and complementary-tick strobes are driven with enabled byte selects and active-looking data, so a stray capture shows up in later reads. A write followed at once by a read of the same pair, and a pseudo-random stream with a command on every slow cycle over a small address range, tell correct beat ordering apart from a read that overtakes or collides with a write.

// File: rtl/bsio_pkg.sv
package bsio_pkg;

   // operation carried by the read/write select
   typedef enum logic {
      OP_WR = 1'b0,
      OP_RD = 1'b1
   } op_e;

   // which edge the next tick stands for
   typedef enum logic {
      PH_MAIN = 1'b0,
      PH_COMP = 1'b1
   } ph_e;

   // ticks from command edge to the edge that consumes the first beat
   localparam int unsigned WR_HEAD_TICKS = 2;
   localparam int unsigned RD_HEAD_TICKS = 3;

endpackage

// File: rtl/bsio_dly.sv
module bsio_dly #(
   parameter int unsigned W     = 8,
   parameter int unsigned DEPTH = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < int'(DEPTH); i++) st[i] <= '0;
      end else begin
         st[0] <= d;
         for (int i = 1; i < int'(DEPTH); i++) st[i] <= st[i-1];
      end
   end

   assign q = st[DEPTH-1];

endmodule

// File: rtl/bsio_store.sv
module bsio_store #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 18,
   parameter int unsigned NB = 2
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] wa,
   input  logic [DW-1:0] wd,
   input  logic [NB-1:0] wbn,
   input  logic [AW-1:0] ra,
   output logic [DW-1:0] rd
);

   localparam int unsigned DEPTH = 1 << AW;
   localparam int unsigned LW    = DW / NB;

   // one bank per byte lane, so each lane carries its own enable
   for (genvar g = 0; g < int'(NB); g++) begin : g_lane
      logic [LW-1:0] bank [DEPTH];

      always_ff @(posedge clk) begin
         if (we && !wbn[g]) bank[wa] <= wd[g*LW +: LW];
      end

      assign rd[g*LW +: LW] = bank[ra];
   end

endmodule

// File: rtl/bsio_wbeat.sv
module bsio_wbeat #(
   parameter int unsigned AW = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hd_v,
   input  logic [AW-1:0] hd_a,
   output logic          we,
   output logic [AW-1:0] wa
);

   localparam logic [AW-1:0] MATE = AW'(1);

   logic          tl_v;
   logic [AW-1:0] tl_a;

   // second beat follows the first by one tick at the pair partner
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl_v <= 1'b0;
         tl_a <= '0;
      end else begin
         tl_v <= hd_v;
         tl_a <= hd_a ^ MATE;
      end
   end

   assign we = hd_v | tl_v;
   assign wa = hd_v ? hd_a : tl_a;

endmodule

// File: rtl/bsio_rbeat.sv
module bsio_rbeat #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 18
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hd_v,
   input  logic [AW-1:0] hd_a,
   input  logic [DW-1:0] rdata,
   output logic [AW-1:0] ra,
   output logic [DW-1:0] dout,
   output logic          dvld
);

   localparam logic [AW-1:0] MATE = AW'(1);

   logic          tl_v;
   logic [AW-1:0] tl_a;

   // storage is looked up on the tick the beat leaves, never earlier
   assign ra = hd_v ? hd_a : tl_a;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tl_v <= 1'b0;
         tl_a <= '0;
         dout <= '0;
         dvld <= 1'b0;
      end else if (hd_v) begin
         tl_v <= 1'b1;
         tl_a <= hd_a ^ MATE;
         dout <= rdata;
         dvld <= 1'b1;
      end else if (tl_v) begin
         tl_v <= 1'b0;
         dout <= rdata;
         dvld <= 1'b1;
      end else begin
         dout <= '0;
         dvld <= 1'b0;
      end
   end

endmodule

// File: rtl/bsio_core.sv
module bsio_core
   import bsio_pkg::*;
#(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 18,
   parameter int unsigned NB = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_n,
   input  logic          rw,
   input  logic [AW-1:0] addr,
   input  logic [DW-1:0] din,
   input  logic [NB-1:0] bw_n,
   output logic [DW-1:0] dout,
   output logic          dout_vld,
   output logic          beat_ph
);

   localparam int unsigned SW = AW + 1;

   // elaboration-time parameter checks
   if (AW < 1 || AW > 16) begin : g_bad_aw
      $error("bsio_core: AW must be in 1..16");
   end
   if (NB < 1 || (DW % NB) != 0) begin : g_bad_nb
      $error("bsio_core: DW must split evenly into NB lanes");
   end

   ph_e ph;

   always_ff @(posedge clk) begin
      if (!rst_n) ph <= PH_MAIN;
      else        ph <= (ph == PH_MAIN) ? PH_COMP : PH_MAIN;
   end

   assign beat_ph = ph;

   // command decode, main-edge ticks only
   logic go, rd_go, wr_go;
   assign go    = !ld_n && (ph == PH_MAIN);
   assign rd_go = go && (op_e'(rw) == OP_RD);
   assign wr_go = go && (op_e'(rw) == OP_WR);

   logic [SW-1:0] wr_q, rd_q;

   bsio_dly #(.W(SW), .DEPTH(WR_HEAD_TICKS)) u_wdly (
      .clk(clk), .rst_n(rst_n), .d({wr_go, addr}), .q(wr_q)
   );

   bsio_dly #(.W(SW), .DEPTH(RD_HEAD_TICKS)) u_rdly (
      .clk(clk), .rst_n(rst_n), .d({rd_go, addr}), .q(rd_q)
   );

   logic          we;
   logic [AW-1:0] wa, ra;
   logic [DW-1:0] rdata;

   bsio_wbeat #(.AW(AW)) u_wbeat (
      .clk(clk), .rst_n(rst_n),
      .hd_v(wr_q[SW-1]), .hd_a(wr_q[AW-1:0]),
      .we(we), .wa(wa)
   );

   bsio_store #(.AW(AW), .DW(DW), .NB(NB)) u_store (
      .clk(clk), .we(we), .wa(wa), .wd(din), .wbn(bw_n),
      .ra(ra), .rd(rdata)
   );

   bsio_rbeat #(.AW(AW), .DW(DW)) u_rbeat (
      .clk(clk), .rst_n(rst_n),
      .hd_v(rd_q[SW-1]), .hd_a(rd_q[AW-1:0]),
      .rdata(rdata), .ra(ra), .dout(dout), .dvld(dout_vld)
   );

endmodule

// File: rtl/bsio_chk.sv
module bsio_chk #(
   parameter int unsigned AW = 6,
   parameter int unsigned DW = 18
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ld_n,
   input logic          rw,
   input logic [AW-1:0] addr,
   input logic [DW-1:0] dout,
   input logic          dout_vld,
   input logic          beat_ph
);

   // R11: phase flips on every tick out of reset
   a_r11_phase_flip: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> (beat_ph != $past(beat_ph)));

   // R6: idle output bus carries zeros
   a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_vld |-> (dout == '0));

   // R6: a read accepted on a main edge is on the bus four samples later
   a_r6_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $past(!ld_n && rw && !beat_ph, 4) |-> dout_vld);

   // R4: a first beat is always followed by its partner beat
   a_r4_pair_follows: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_vld && !beat_ph) |=> dout_vld);

   // R4: a second beat is always preceded by a first beat
   a_r4_pair_preceded: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_vld && beat_ph) |-> $past(dout_vld));

endmodule

bind bsio_core bsio_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
   .dout(dout), .dout_vld(dout_vld), .beat_ph(beat_ph)
);

// File: tb/bsio_core_test.sv
module bsio_core_test;

   localparam int AW    = 6;
   localparam int DW    = 18;
   localparam int NB    = 2;
   localparam int LW    = DW / NB;
   localparam int NT    = 4096;
   localparam int WORDS = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          ld_n = 1'b1;
   logic          rw = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] din = '0;
   logic [NB-1:0] bw_n = '1;
   logic [DW-1:0] dout;
   logic          dout_vld;
   logic          beat_ph;

   bsio_core #(.AW(AW), .DW(DW), .NB(NB)) uut (
      .clk(clk), .rst_n(rst_n), .ld_n(ld_n), .rw(rw), .addr(addr),
      .din(din), .bw_n(bw_n), .dout(dout), .dout_vld(dout_vld),
      .beat_ph(beat_ph)
   );

   always #4 clk = ~clk;

   int total = 0;
   int bad = 0;
   int n = 0;
   string tag = "R1";
   int unsigned lcg = 32'h1234_5678;

   // reference model: memory plus per-tick schedules
   bit [DW-1:0] ref_m [WORDS];
   bit          wb_v [NT];
   bit [AW-1:0] wb_a [NT];
   bit [DW-1:0] wb_d [NT];
   bit [NB-1:0] wb_m [NT];
   bit          ex_v [NT];
   bit [AW-1:0] ex_a [NT];

   task automatic chk(input bit ok, input string t, input logic [31:0] act,
                      input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s tick=%0d act=%0h exp=%0h", t, n, act, exp);
      end
   endtask

   function automatic int unsigned rnd();
      lcg = lcg * 32'd1103515245 + 32'd12345;
      return lcg >> 8;
   endfunction

   // one tick: edge, model update, sample at the falling edge, next drive
   task automatic tick();
      bit          ev;
      bit [DW-1:0] e;
      @(posedge clk);
      ev = ex_v[n];
      e  = ev ? ref_m[ex_a[n]] : '0;
      if (wb_v[n]) begin
         for (int k = 0; k < NB; k++)
            if (!wb_m[n][k]) ref_m[wb_a[n]][k*LW +: LW] = wb_d[n][k*LW +: LW];
      end
      @(negedge clk);
      chk(dout_vld === ev, {tag, " R6 valid"}, 32'(dout_vld), 32'(ev));
      chk(dout === e, {tag, " R6 data"}, 32'(dout), 32'(e));
      n++;
      chk(beat_ph === n[0], "R11 phase", 32'(beat_ph), 32'(n[0]));
      ld_n = 1'b1;
      rw   = 1'b0;
      addr = AW'(rnd());
      // unscheduled ticks drive live-looking data with enabled selects
      din  = wb_v[n] ? wb_d[n] : DW'(rnd());
      bw_n = wb_v[n] ? wb_m[n] : '0;
   endtask

   // one slow cycle carrying a command; junk leaves a strobe on the comp tick
   task automatic cmd(input bit rd, input int a, input bit [DW-1:0] d0,
                      input bit [NB-1:0] m0, input bit [DW-1:0] d1,
                      input bit [NB-1:0] m1, input bit junk);
      bit [AW-1:0] aa;
      aa = AW'(a);
      chk(beat_ph === 1'b0, "R3 main tick", 32'(beat_ph), 0);
      ld_n = 1'b0;
      rw   = rd;
      addr = aa;
      if (rd) begin
         ex_v[n+3] = 1'b1; ex_a[n+3] = aa;
         ex_v[n+4] = 1'b1; ex_a[n+4] = aa ^ AW'(1);
      end else begin
         wb_v[n+2] = 1'b1; wb_a[n+2] = aa;          wb_d[n+2] = d0; wb_m[n+2] = m0;
         wb_v[n+3] = 1'b1; wb_a[n+3] = aa ^ AW'(1); wb_d[n+3] = d1; wb_m[n+3] = m1;
      end
      tick();
      if (junk) begin
         ld_n = 1'b0;
         rw   = ~rd;
         addr = ~aa;
      end
      tick();
   endtask

   task automatic wr(input int a, input bit [DW-1:0] d0, input bit [NB-1:0] m0,
                     input bit [DW-1:0] d1, input bit [NB-1:0] m1);
      cmd(1'b0, a, d0, m0, d1, m1, 1'b0);
   endtask

   task automatic rd(input int a);
      cmd(1'b1, a, '0, '0, '0, '0, 1'b0);
   endtask

   task automatic idle(input int cycles);
      for (int i = 0; i < 2 * cycles; i++) begin
         rw = (i % 2 == 0);
         tick();
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(dout_vld === 1'b0, "R1 valid", 32'(dout_vld), 0);
      chk(dout === '0, "R1 data", 32'(dout), 0);
      chk(beat_ph === 1'b0, "R1 phase", 32'(beat_ph), 0);
      rst_n = 1'b1;
      n = 0;
      bw_n = '0;
      din = DW'(rnd());

      // R3 R5: fill every pair with full-mask writes
      tag = "R3 R5 fill";
      for (int a = 0; a < WORDS; a += 2)
         wr(a, DW'(a * 4099 + 17), '0, DW'(a * 2731 + 5), '0);
      idle(2);

      // R3 R6: spaced reads of every pair
      tag = "R3 R6 readback";
      for (int a = 0; a < WORDS; a += 2) begin
         rd(a);
         idle(1);
      end
      idle(2);

      // R4: odd first address wraps inside the pair
      tag = "R4 wrap";
      wr(9, 18'h2A5A5, '0, 18'h15A5A, '0);
      idle(1);
      rd(8); idle(1);
      rd(9); idle(2);

      // R7: single-lane and all-masked writes
      tag = "R7 lanes";
      wr(20, 18'h3FFFF, 2'b10, 18'h3FFFF, 2'b01);
      idle(1);
      wr(22, 18'h00000, 2'b11, 18'h12345, 2'b11);
      idle(1);
      rd(20); idle(1);
      rd(22); idle(2);

      // R8: different masks per beat in one burst
      tag = "R8 beat masks";
      wr(31, 18'h0ABCD, 2'b01, 18'h31111, 2'b00);
      idle(1);
      rd(30); idle(2);

      // R2: idle cycles with enabled selects must not write
      tag = "R2 no-op";
      idle(6);
      rd(40); idle(1); rd(44); idle(2);

      // R12: strobes on complementary ticks are ignored
      tag = "R12 comp strobe";
      cmd(1'b0, 50, 18'h1F0F0, '0, 18'h20F0F, '0, 1'b1);
      idle(1);
      cmd(1'b1, 50, '0, '0, '0, '0, 1'b1);
      idle(3);
      rd(12); idle(2);

      // R9: read directly after a write to the same pair
      tag = "R9 write then read";
      wr(34, 18'h3C3C3, '0, 18'h0C3C3, 2'b10);
      rd(34);
      wr(37, 18'h11111, 2'b01, 18'h22222, '0);
      rd(37);
      idle(3);

      // R10: a command every slow cycle, mixed, small address range
      tag = "R10 stream";
      for (int i = 0; i < 120; i++) begin
         if (rnd() % 2 == 1) rd(int'(rnd() % 8));
         else wr(int'(rnd() % 8), DW'(rnd()), NB'(rnd()), DW'(rnd()), NB'(rnd()));
      end
      idle(3);
      tag = "R10 after stream";
      for (int a = 0; a < 8; a += 2) rd(a);
      idle(3);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule